// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Input Shaping

This block collects fifteen interrupt sources and offers the most urgent one that is pending and enabled to a processor core. The sources are internal peripheral events, an OR of three hardware-error flags, a watchdog request and five external interrupt pins. Each source has a fixed rank and a trap-type code from 11h to 1Fh, and a larger code wins. The core sees only the low nibble of the winning code, together with a valid flag, from a register stage after the priority logic.

Each external pin passes through a two-flop synchroniser. A shaping register then chooses its active level and whether it latches on an edge or follows the level. The core acknowledges a source by giving its code nibble. The controller clears that pending bit and, when the source is an external pin, pulses a one-hot acknowledge back to that pin alone. Software reaches the pending, enable-mask and shaping registers over a plain write-strobe and read-data bus.

Top module: `irq_ctrl_top`

## Requirements
- R1: After synchronous reset, the pending register reads 0, the mask register reads 3FFFh (every maskable source masked), the shaping register reads 0 (all pins active-low and level-sensitive), and `req_valid_o` and `ext_ack_o` are 0.
- R2: Source index i (0..14) has trap code 11h+i and reports `req_code_o` = i+1. The indices are: 0 hardware-error OR, 1 external pin 0, 2 external pin 1, 3 to 8 `periph_evt_i[0..5]`, 9 external pin 2, 10 external pin 3, 11 `periph_evt_i[6]`, 12 `periph_evt_i[7]`, 13 external pin 4, 14 watchdog.
- R3: `req_valid_o`/`req_code_o` show the highest-index source that is pending and unmasked. They come from a register loaded from the pending and mask state of the previous cycle, so an internal event sampled at one clock edge appears after the second edge.
- R4: The watchdog source (index 14) has no mask bit and always competes. It is set by `wdog_evt_i` or by `wdog_pin_i` after a two-flop synchroniser.
- R5: Mask register bit i (address 1, bits 13:0) set to 1 keeps source i out of the selection, but its pending bit still sets.
- R6: Source 0 sets when any bit of `hw_err_i` is high.
- R7: Shaping register (address 2): bit k of [4:0] set to 1 makes pin k active-high (0 = active-low), and bit 8+k set to 1 makes pin k edge-sensitive. In edge mode a newly asserted level, seen after two synchroniser flops, sets the pending bit once, and a held level does not set it again.
- R8: In level mode, the pending bit of an external pin equals its asserted level one edge after the synchroniser output. Acknowledges and register writes leave no lasting effect on it.
- R9: `ack_i` with `ack_code_i` = c (1..15) clears the pending bit of source c-1. Code 0 changes nothing.
- R10: One cycle after an acknowledge whose code belongs to external pin k, `ext_ack_o` is one-hot on bit k. It is 0 in every other cycle.
- R11: A set event on a source in the same cycle as its acknowledge, or as a software write of 0 to its pending bit, leaves the bit set.
- R12: A write to address 0 replaces pending bits [14:0] (level-mode pins excepted). The mask and shaping registers read back what was written, limited to their defined bits. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_evt_i | input | 8 | Internal peripheral event requests |
| hw_err_i | input | 3 | Hardware error flags, ORed into source 0 |
| wdog_evt_i | input | 1 | Internal watchdog time-out |
| wdog_pin_i | input | 1 | External watchdog request pin (asynchronous, active-high) |
| ext_pin_i | input | 5 | External interrupt pins (asynchronous) |
| ack_i | input | 1 | Core acknowledge strobe |
| ack_code_i | input | 4 | Code nibble being acknowledged |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| req_valid_o | output | 1 | An interrupt is being requested |
| req_code_o | output | 4 | Low nibble of the winning trap code |
| ext_ack_o | output | 5 | One-hot acknowledge to the serviced external pin |

## Verification
The pending logic has three writers that can act in the same cycle: a set event, the core's acknowledge and a software write. The bench provokes this by driving a peripheral pulse together with an acknowledge of the same code, and then together with a register write of zero. It judges the result by reading the pending register and watching the request stay up, and a reference model checks the same thing every clock. Level-mode pins add a fourth writer that overrides the rest, so the same collision is repeated on a held external pin.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int NSRC     = 15;
    localparam int NEXT     = 5;
    localparam int NPER     = 8;
    localparam int NHWE     = 3;
    localparam int REG_W    = 16;
    localparam int CODE_W   = 4;
    localparam int IDX_HWE  = 0;
    localparam int IDX_WDOG = NSRC - 1;
    localparam int NMASK    = NSRC - 1;
    localparam int SHP_EDGE = 8;

    typedef logic [NSRC-1:0]   src_vec_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  valid;
        code_t code;
    } irq_req_t;

    typedef struct packed {
        logic [NEXT-1:0] edge_mode;
        logic [NEXT-1:0] act_high;
    } shape_t;

    typedef enum logic [1:0] {
        RA_PEND  = 2'd0,
        RA_MASK  = 2'd1,
        RA_SHAPE = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    function automatic int ext_src_idx(input int k);
        case (k)
            0:       return 1;
            1:       return 2;
            2:       return 9;
            3:       return 10;
            default: return 13;
        endcase
    endfunction

    function automatic int per_src_idx(input int p);
        case (p)
            0:       return 3;
            1:       return 4;
            2:       return 5;
            3:       return 6;
            4:       return 7;
            5:       return 8;
            6:       return 11;
            default: return 12;
        endcase
    endfunction

    function automatic irq_req_t pick_highest(input src_vec_t elig);
        irq_req_t r;
        r = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i]) begin
                r.valid = 1'b1;
                r.code  = code_t'(i + 1);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/irq_ext_shape.sv
module irq_ext_shape
    import irq_ctrl_pkg::*;
#(
    parameter int NPIN   = NEXT,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] act_high_i,
    output logic [NPIN-1:0] level_o,
    output logic [NPIN-1:0] edge_o
);
    logic [NPIN-1:0] synced;
    logic [NPIN-1:0] level_q;

    for (genvar k = 0; k < NPIN; k++) begin : g_pin
        irq_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .d_i (pin_i[k]),
            .q_o (synced[k])
        );
        assign level_o[k] = act_high_i[k] ? synced[k] : ~synced[k];
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= level_o;
    end

    assign edge_o = level_o & ~level_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  src_vec_t         set_vec_i,
    input  src_vec_t         lvl_sel_i,
    input  src_vec_t         lvl_val_i,
    input  logic             ack_i,
    input  code_t            ack_code_i,
    input  logic             we_i,
    input  logic [1:0]       addr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output src_vec_t         pend_o,
    output src_vec_t         mask_o,
    output shape_t           shape_o
);
    src_vec_t         pend_q, pend_nxt;
    logic [NMASK-1:0] mask_q;
    shape_t           shape_q;
    reg_addr_e        ra;
    logic             wr_pend;
    logic             unused_wdata_msb;

    assign ra               = reg_addr_e'(addr_i);
    assign wr_pend          = we_i && (ra == RA_PEND);
    assign unused_wdata_msb = wdata_i[REG_W-1];

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            pend_nxt[i] = wr_pend ? wdata_i[i] : pend_q[i];
            if (ack_i && (ack_code_i == code_t'(i + 1))) pend_nxt[i] = 1'b0;
            if (set_vec_i[i]) pend_nxt[i] = 1'b1;
            if (lvl_sel_i[i]) pend_nxt[i] = lvl_val_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            mask_q  <= '1;
            shape_q <= '0;
        end else begin
            pend_q <= pend_nxt;
            if (we_i && (ra == RA_MASK)) mask_q <= wdata_i[NMASK-1:0];
            if (we_i && (ra == RA_SHAPE)) begin
                shape_q.act_high  <= wdata_i[NEXT-1:0];
                shape_q.edge_mode <= wdata_i[SHP_EDGE +: NEXT];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (ra)
            RA_PEND:  rdata_o[NSRC-1:0]  = pend_q;
            RA_MASK:  rdata_o[NMASK-1:0] = mask_q;
            RA_SHAPE: begin
                rdata_o[NEXT-1:0]        = shape_q.act_high;
                rdata_o[SHP_EDGE +: NEXT] = shape_q.edge_mode;
            end
            RA_NONE:  rdata_o = '0;
        endcase
    end

    assign pend_o  = pend_q;
    assign mask_o  = {1'b0, mask_q};
    assign shape_o = shape_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pend_i,
    input  src_vec_t mask_i,
    output irq_req_t req_o
);
    src_vec_t elig;
    irq_req_t win;

    assign elig = pend_i & ~mask_i;

    always_comb win = pick_highest(elig);

    always_ff @(posedge clk) begin
        if (rst) req_o <= '0;
        else     req_o <= win;
    end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPER-1:0]   periph_evt_i,
    input  logic [NHWE-1:0]   hw_err_i,
    input  logic              wdog_evt_i,
    input  logic              wdog_pin_i,
    input  logic [NEXT-1:0]   ext_pin_i,
    input  logic              ack_i,
    input  logic [CODE_W-1:0] ack_code_i,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              req_valid_o,
    output logic [CODE_W-1:0] req_code_o,
    output logic [NEXT-1:0]   ext_ack_o
);
    src_vec_t        set_vec, lvl_sel, lvl_val, pend_vec, mask_vec;
    shape_t          shape;
    logic [NEXT-1:0] ext_lvl, ext_edge, ext_ack_nxt;
    logic            wdog_pin_s;
    irq_req_t        req;

    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wdog_sync (
        .clk (clk),
        .rst (rst),
        .d_i (wdog_pin_i),
        .q_o (wdog_pin_s)
    );

    irq_ext_shape #(.NPIN(NEXT), .STAGES(SYNC_STAGES)) u_shape (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (ext_pin_i),
        .act_high_i (shape.act_high),
        .level_o    (ext_lvl),
        .edge_o     (ext_edge)
    );

    always_comb begin
        set_vec = '0;
        lvl_sel = '0;
        lvl_val = '0;
        for (int p = 0; p < NPER; p++) set_vec[per_src_idx(p)] = periph_evt_i[p];
        set_vec[IDX_HWE]  = |hw_err_i;
        set_vec[IDX_WDOG] = wdog_evt_i | wdog_pin_s;
        for (int k = 0; k < NEXT; k++) begin
            set_vec[ext_src_idx(k)] = shape.edge_mode[k] & ext_edge[k];
            lvl_sel[ext_src_idx(k)] = ~shape.edge_mode[k];
            lvl_val[ext_src_idx(k)] = ext_lvl[k];
        end
    end

    irq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .set_vec_i  (set_vec),
        .lvl_sel_i  (lvl_sel),
        .lvl_val_i  (lvl_val),
        .ack_i      (ack_i),
        .ack_code_i (ack_code_i),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .pend_o     (pend_vec),
        .mask_o     (mask_vec),
        .shape_o    (shape)
    );

    irq_prio u_prio (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend_vec),
        .mask_i (mask_vec),
        .req_o  (req)
    );

    always_comb begin
        for (int k = 0; k < NEXT; k++)
            ext_ack_nxt[k] = ack_i && (ack_code_i == code_t'(ext_src_idx(k) + 1));
    end

    always_ff @(posedge clk) begin
        if (rst) ext_ack_o <= '0;
        else     ext_ack_o <= ext_ack_nxt;
    end

    assign req_valid_o = req.valid;
    assign req_code_o  = req.code;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        ack_i,
    input logic [14:0] pend,
    input logic [14:0] set_vec,
    input logic        req_valid_o,
    input logic [3:0]  req_code_o,
    input logic [4:0]  ext_ack_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!req_valid_o && ext_ack_o == 5'd0));

    assert_code_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> (req_code_o != 4'd0));

    assert_req_has_source_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> $past(pend != 15'd0));

    assert_wdog_wins_R4: assert property (@(posedge clk) disable iff (rst)
        pend[14] |=> (req_valid_o && req_code_o == 4'hF));

    assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ext_ack_o));

    assert_ack_caused_R10: assert property (@(posedge clk) disable iff (rst)
        (ext_ack_o != 5'd0) |-> $past(ack_i));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        set_vec[14] |=> pend[14]);
endmodule

bind irq_ctrl_top irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack_i       (ack_i),
    .pend        (pend_vec),
    .set_vec     (set_vec),
    .req_valid_o (req_valid_o),
    .req_code_o  (req_code_o),
    .ext_ack_o   (ext_ack_o)
);

// File: tb/test_irq_ctrl_top.sv
module test_irq_ctrl_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  periph_evt = '0;
    logic [2:0]  hw_err = '0;
    logic        wdog_evt = 1'b0, wdog_pin = 1'b0;
    logic [4:0]  ext_pin = 5'h1F;
    logic        ack = 1'b0;
    logic [3:0]  ack_code = '0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        req_valid;
    logic [3:0]  req_code;
    logic [4:0]  ext_ack;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_ctrl_top i_irq_ctrl_top (
        .clk(clk), .rst(rst), .periph_evt_i(periph_evt), .hw_err_i(hw_err),
        .wdog_evt_i(wdog_evt), .wdog_pin_i(wdog_pin), .ext_pin_i(ext_pin),
        .ack_i(ack), .ack_code_i(ack_code), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_valid_o(req_valid),
        .req_code_o(req_code), .ext_ack_o(ext_ack)
    );

    // Behavioural reference model
    int EXT_MAP[5] = '{1, 2, 9, 10, 13};
    int PER_MAP[8] = '{3, 4, 5, 6, 7, 8, 11, 12};
    logic [14:0] m_pend;
    logic [13:0] m_mask;
    logic [4:0]  m_pol, m_edg, m_s1, m_s2, m_aq, m_eack;
    logic        m_w1, m_w2, m_rv;
    logic [3:0]  m_rc;

    always @(posedge clk) begin : model
        logic [4:0]  asr, det;
        logic [14:0] np;
        if (rst) begin
            m_pend = '0; m_mask = '1; m_pol = '0; m_edg = '0;
            m_s1 = '1; m_s2 = '1; m_aq = '0; m_w1 = 0; m_w2 = 0;
            m_rv = 0; m_rc = '0; m_eack = '0;
        end else begin
            asr = (m_s2 & m_pol) | (~m_s2 & ~m_pol);
            det = asr & ~m_aq;
            np = (we && addr == 2'd0) ? wdata[14:0] : m_pend;
            if (ack && ack_code != 4'd0) np[ack_code - 1] = 1'b0;
            for (int p = 0; p < 8; p++) if (periph_evt[p]) np[PER_MAP[p]] = 1'b1;
            if (|hw_err) np[0] = 1'b1;
            if (wdog_evt || m_w2) np[14] = 1'b1;
            for (int k = 0; k < 5; k++) begin
                if (m_edg[k]) begin
                    if (det[k]) np[EXT_MAP[k]] = 1'b1;
                end else np[EXT_MAP[k]] = asr[k];
            end
            m_rv = 0; m_rc = '0;
            for (int i = 0; i < 15; i++)
                if (m_pend[i] && (i == 14 || !m_mask[i])) begin m_rv = 1; m_rc = 4'(i + 1); end
            for (int k = 0; k < 5; k++) m_eack[k] = ack && (ack_code == 4'(EXT_MAP[k] + 1));
            if (we && addr == 2'd1) m_mask = wdata[13:0];
            if (we && addr == 2'd2) begin m_pol = wdata[4:0]; m_edg = wdata[12:8]; end
            m_s2 = m_s1; m_s1 = ext_pin; m_w2 = m_w1; m_w1 = wdog_pin;
            m_aq = asr; m_pend = np;
        end
    end

    function automatic logic [15:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return {1'b0, m_pend};
            2'd1:    return {2'b0, m_mask};
            2'd2:    return {3'b0, m_edg, 3'b0, m_pol};
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            chk("R3", "req_valid", {15'd0, req_valid}, {15'd0, m_rv});
            chk("R2", "req_code", {12'd0, req_code}, {12'd0, m_rc});
            chk("R10", "ext_ack", {11'd0, ext_ack}, {11'd0, m_eack});
            chk("R12", "rdata", rdata, m_rdata(addr));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); we = 1; addr = a; wdata = d;
        @(negedge clk); we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic pulse_per(input logic [7:0] b);
        @(negedge clk); periph_evt = b;
        @(negedge clk); periph_evt = '0;
    endtask

    task automatic do_ack(input logic [3:0] c);
        @(negedge clk); ack = 1; ack_code = c;
        @(negedge clk); ack = 0; ack_code = '0;
    endtask

    task automatic chk_req(input string r, input logic v, input logic [3:0] c);
        chk(r, "req_valid", {15'd0, req_valid}, {15'd0, v});
        if (v) chk(r, "req_code", {12'd0, req_code}, {12'd0, c});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] v;
        cyc(4);
        rst = 0;
        cyc(2);
        // R1 reset state
        chk_req("R1", 1'b0, 4'h0);
        chk("R1", "ext_ack", {11'd0, ext_ack}, 16'h0);
        rd(2'd0, v); chk("R1", "pending", v, 16'h0000);
        rd(2'd1, v); chk("R1", "mask", v, 16'h3FFF);
        rd(2'd2, v); chk("R1", "shape", v, 16'h0000);

        // R3 priority between two simultaneous events
        wr(2'd1, 16'h0000);
        pulse_per(8'h81);
        cyc(2);
        chk_req("R3", 1'b1, 4'hD);
        rd(2'd0, v); chk("R3", "pending", v, 16'h1008);
        do_ack(4'hD); cyc(2);
        chk_req("R9", 1'b1, 4'h4);
        do_ack(4'h4); cyc(2);
        chk_req("R9", 1'b0, 4'h0);

        // R2 code of every peripheral input
        for (int p = 0; p < 8; p++) begin
            pulse_per(8'(1 << p));
            cyc(2);
            chk_req("R2", 1'b1, 4'(PER_MAP[p] + 1));
            do_ack(4'(PER_MAP[p] + 1));
            cyc(1);
        end

        // R5 mask blocks selection, pending still set
        wr(2'd1, 16'h1000);
        pulse_per(8'h80); cyc(2);
        chk_req("R5", 1'b0, 4'h0);
        rd(2'd0, v); chk("R5", "pending", v, 16'h1000);

        // R4 watchdog ignores mask
        wr(2'd1, 16'hFFFF);
        @(negedge clk); wdog_evt = 1; @(negedge clk); wdog_evt = 0;
        cyc(2);
        chk_req("R4", 1'b1, 4'hF);
        do_ack(4'hF); cyc(2);
        chk_req("R4", 1'b0, 4'h0);
        @(negedge clk); wdog_pin = 1; @(negedge clk); wdog_pin = 0;
        cyc(4);
        chk_req("R4", 1'b1, 4'hF);
        do_ack(4'hF);
        wr(2'd0, 16'h0000);

        // R6 hardware error OR
        wr(2'd1, 16'h0000);
        @(negedge clk); hw_err = 3'b010; @(negedge clk); hw_err = '0;
        cyc(2);
        chk_req("R6", 1'b1, 4'h1);
        do_ack(4'h1); cyc(2);

        // R8 level mode on pin 0 (active-low)
        @(negedge clk); ext_pin[0] = 1'b0;
        cyc(5);
        chk_req("R8", 1'b1, 4'h2);
        do_ack(4'h2); cyc(2);
        rd(2'd0, v); chk("R8", "pending held by level", v & 16'h0002, 16'h0002);
        @(negedge clk); ext_pin[0] = 1'b1;
        cyc(5);
        chk_req("R8", 1'b0, 4'h0);
        wr(2'd0, 16'h0002); cyc(1);
        rd(2'd0, v); chk("R8", "write ignored", v & 16'h0002, 16'h0000);

        // R7 edge mode on pin 4 (active-low)
        wr(2'd2, 16'h1000);
        @(negedge clk); ext_pin[4] = 1'b0;
        cyc(5);
        chk_req("R7", 1'b1, 4'hE);
        @(negedge clk); ack = 1; ack_code = 4'hE;
        @(negedge clk); ack = 0; ack_code = '0;
        chk("R10", "ext_ack pin4", {11'd0, ext_ack}, 16'h0010);
        @(negedge clk);
        chk("R10", "ext_ack cleared", {11'd0, ext_ack}, 16'h0000);
        cyc(4);
        chk_req("R7", 1'b0, 4'h0);
        @(negedge clk); ext_pin[4] = 1'b1;
        cyc(4);
        @(negedge clk); ext_pin[4] = 1'b0;
        cyc(5);
        chk_req("R7", 1'b1, 4'hE);
        do_ack(4'hE); cyc(2);

        // R7 polarity on pin 3
        @(negedge clk); ext_pin[3] = 1'b0;
        cyc(5);
        rd(2'd0, v); chk("R7", "pin3 low active-low", v & 16'h0400, 16'h0400);
        wr(2'd2, 16'h1008);
        cyc(5);
        rd(2'd0, v); chk("R7", "pin3 low active-high", v & 16'h0400, 16'h0000);
        @(negedge clk); ext_pin[3] = 1'b1;
        cyc(5);
        chk_req("R7", 1'b1, 4'hB);
        @(negedge clk); ext_pin[3] = 1'b0;
        cyc(5);
        chk_req("R7", 1'b0, 4'h0);

        // R10 non-external code gives no pin acknowledge
        pulse_per(8'h80); cyc(1);
        @(negedge clk); ack = 1; ack_code = 4'hD;
        @(negedge clk); ack = 0; ack_code = '0;
        chk("R10", "ext_ack none", {11'd0, ext_ack}, 16'h0000);
        cyc(2);

        // R11 set wins over acknowledge and over write
        pulse_per(8'h80); cyc(2);
        @(negedge clk); periph_evt = 8'h80; ack = 1; ack_code = 4'hD;
        @(negedge clk); periph_evt = '0; ack = 0; ack_code = '0;
        cyc(1);
        rd(2'd0, v); chk("R11", "set beats ack", v & 16'h1000, 16'h1000);
        chk_req("R11", 1'b1, 4'hD);
        @(negedge clk); periph_evt = 8'h80; we = 1; addr = 2'd0; wdata = 16'h0000;
        @(negedge clk); periph_evt = '0; we = 0;
        rd(2'd0, v); chk("R11", "set beats write", v & 16'h1000, 16'h1000);
        do_ack(4'hD); cyc(2);

        // R12 pending write, R9 code 0
        wr(2'd0, 16'h0021); cyc(1);
        rd(2'd0, v); chk("R12", "pending forced", v & 16'h0021, 16'h0021);
        cyc(1);
        chk_req("R12", 1'b1, 4'h6);
        do_ack(4'h0); cyc(1);
        rd(2'd0, v); chk("R9", "code 0 no effect", v & 16'h0021, 16'h0021);
        wr(2'd0, 16'h0000); cyc(1);
        rd(2'd0, v); chk("R12", "pending cleared", v & 16'h0021, 16'h0000);
        wr(2'd1, 16'h2AAA);
        rd(2'd1, v); chk("R12", "mask readback", v, 16'h2AAA);
        wr(2'd1, 16'hFFFF);
        rd(2'd1, v); chk("R12", "mask width", v, 16'h3FFF);
        rd(2'd3, v); chk("R12", "spare address", v, 16'h0000);
        wr(2'd2, 16'hFFFF);
        rd(2'd2, v); chk("R12", "shape width", v, 16'h1F1F);
        cyc(6);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule